// File: doc/BRIEF.md
# Serial LED Column Streamer

This block drives a cascade of sixteen external 8-bit shift-and-latch registers behind a 16-by-8 LED ticker. Each shift-event pulse adds one new column to the chain. A host fills an internal column buffer through a plain write port. It also sets three pointers: the current position, the end position and the restart position. The end position is the address one past the last column in use.

On each accepted event the block reads the byte at the current pointer and shifts it out on a single serial data line, one clock pulse per bit. One strobe pulse then moves the whole chain into the output latches, and the current pointer advances. When the advanced pointer reaches the end position, it reloads from the restart position instead of returning to address zero. Every phase can be stretched by a programmable number of cycles, so slow external registers still meet their timing at any system clock rate. An event that arrives during a transfer is held and served as soon as the transfer finishes.

Top module: `col_streamer`

## Requirements
- R1: With `lsb_first_i` low, the column byte is shifted out starting with bit 7 and ending with bit 0, so bit 7 lands on the last stage of the first external register.
- R2: Each column produces exactly eight rising edges on `ser_clk_o`. `ser_data_o` is valid before each rising edge and does not change while `ser_clk_o` is high.
- R3: After the eighth clock pulse, exactly one `ser_strobe_o` pulse is issued per column, and `ser_clk_o` is low for the whole strobe.
- R4: After each column the current pointer increments by one. If the incremented value equals the end pointer, the current pointer is loaded with the restart pointer instead.
- R5: A column byte of zero is sent as eight zero bits, and the pointer sequence continues normally past it.
- R6: Every clock-low phase, clock-high phase and strobe phase lasts `stretch_i`+1 cycles. `stretch_i` is sampled when the event is accepted.
- R7: A shift event that arrives while a column is in progress is remembered. The next transfer starts one idle cycle after the strobe ends, so no event is lost.
- R8: `busy_o` rises in the cycle after an event is accepted and falls in the same cycle that the strobe pulse ends.
- R9: Pointer writes (`ptr_we_i`, with `ptr_sel_i` 0 = current, 1 = end, 2 = restart, 3 = no effect) take effect only while `busy_o` is low. While `busy_o` is high they are ignored.
- R10: After reset, `ser_clk_o`, `ser_strobe_o`, `ser_data_o` and `busy_o` are low. The current pointer equals the restart pointer reset value (0), so the first column sent is buffer address 0.
- R11: With `lsb_first_i` high, the column byte is shifted out starting with bit 0 and ending with bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Column buffer write enable |
| wr_addr_i | input | AW | Column buffer write address |
| wr_data_i | input | 8 | Column byte to store |
| ptr_we_i | input | 1 | Pointer write enable |
| ptr_sel_i | input | 2 | Pointer select: 0 current, 1 end, 2 restart |
| ptr_wdata_i | input | AW | Pointer write value |
| stretch_i | input | SW | Extra cycles added to each clock/strobe phase |
| lsb_first_i | input | 1 | Bit order: 0 MSB first, 1 LSB first |
| shift_evt_i | input | 1 | Shift-event pulse |
| ser_data_o | output | 1 | Serial data to the first register |
| ser_clk_o | output | 1 | Shift clock to all registers |
| ser_strobe_o | output | 1 | Latch strobe to all registers |
| busy_o | output | 1 | Column transfer in progress |

## Verification
The bench rebuilds every column from the serial pins and checks it against the buffer contents in both bit orders. A design with the wrong order would return mirrored bytes.

Pointer sequences are run across the end-to-restart wrap and through a zero-valued column. A block that wrapped to address zero, or treated zero as a terminator, would send the wrong columns.

Every phase is timed at several stretch values, which catches a stretch that is off by one cycle. A second event fired during a transfer must still yield a column; a design that drops it sends one column short. A pointer write issued during a transfer must not disturb the sequence. Finally, `busy_o` is checked one cycle after acceptance and again when the strobe ends.

// File: rtl/col_stream_pkg.sv
package col_stream_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_STRB = 2'd3
  } ser_state_e;

  typedef enum logic [1:0] {
    PSEL_CUR  = 2'd0,
    PSEL_END  = 2'd1,
    PSEL_RST  = 2'd2,
    PSEL_NONE = 2'd3
  } ptr_sel_e;
endpackage

// File: rtl/col_buf.sv
module col_buf #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/ptr_unit.sv
module ptr_unit
  import col_stream_pkg::*;
#(
  parameter int          AW          = 6,
  parameter logic [AW-1:0] RESTART_RST = '0,
  parameter logic [AW-1:0] END_RST     = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idle_i,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          adv_i,
  output logic [AW-1:0] cur_o
);
  logic [AW-1:0] cur_q, end_q, rst_q, cur_inc;

  assign cur_inc = cur_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= RESTART_RST;
      end_q <= END_RST;
      rst_q <= RESTART_RST;
    end else if (adv_i) begin
      cur_q <= (cur_inc == end_q) ? rst_q : cur_inc;
    end else if (idle_i && we_i) begin
      case (ptr_sel_e'(sel_i))
        PSEL_CUR: cur_q <= wdata_i;
        PSEL_END: end_q <= wdata_i;
        PSEL_RST: rst_q <= wdata_i;
        default:  ;
      endcase
    end
  end

  assign cur_o = cur_q;

  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && (cur_q + 1'b1 == end_q)) |=> (cur_q == $past(rst_q)));
  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && (cur_q + 1'b1 != end_q)) |=> (cur_q == $past(cur_q) + 1'b1));
  p_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_i && !adv_i) |=> ($stable(cur_q) && $stable(end_q) && $stable(rst_q)));
endmodule

// File: rtl/ser_engine.sv
module ser_engine
  import col_stream_pkg::*;
#(
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_i,
  input  logic          lsb_first_i,
  input  logic [SW-1:0] stretch_i,
  input  logic [7:0]    col_i,
  output logic          ser_data_o,
  output logic          ser_clk_o,
  output logic          ser_strobe_o,
  output logic          busy_o,
  output logic          adv_o
);
  ser_state_e    st_q;
  logic [SW-1:0] cnt_q, stretch_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;
  logic          lsb_q, pend_q;
  logic          accept, phase_done;

  assign accept     = (st_q == ST_IDLE) && (evt_i || pend_q);
  assign phase_done = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      stretch_q <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      lsb_q     <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      if (accept)                        pend_q <= 1'b0;
      else if (evt_i && st_q != ST_IDLE) pend_q <= 1'b1;

      case (st_q)
        ST_IDLE: if (accept) begin
          st_q      <= ST_LOW;
          cnt_q     <= stretch_i;
          stretch_q <= stretch_i;
          bit_q     <= '0;
          sh_q      <= col_i;
          lsb_q     <= lsb_first_i;
        end
        ST_LOW: begin
          if (phase_done) begin
            st_q  <= ST_HIGH;
            cnt_q <= stretch_q;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_HIGH: begin
          if (phase_done) begin
            cnt_q <= stretch_q;
            if (bit_q == 3'd7) st_q <= ST_STRB;
            else begin
              st_q  <= ST_LOW;
              bit_q <= bit_q + 1'b1;
              sh_q  <= lsb_q ? (sh_q >> 1) : (sh_q << 1);
            end
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_STRB: begin
          if (phase_done) st_q <= ST_IDLE;
          else            cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ser_data_o   = (st_q == ST_LOW || st_q == ST_HIGH) && (lsb_q ? sh_q[0] : sh_q[7]);
  assign ser_clk_o    = (st_q == ST_HIGH);
  assign ser_strobe_o = (st_q == ST_STRB);
  assign busy_o       = (st_q != ST_IDLE);
  assign adv_o        = (st_q == ST_STRB) && phase_done;

  p_eight_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_STRB) |-> (bit_q == 3'd7));
  p_data_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_data_o));
  p_strobe_alone_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_strobe_o |-> !ser_clk_o);
  p_phase_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && !phase_done) |=> (st_q == $past(st_q)));
  p_pend_served_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_o && pend_q) |=> ##1 (st_q == ST_LOW));
endmodule

// File: rtl/col_streamer.sv
module col_streamer #(
  parameter int DEPTH = 64,
  parameter int SW    = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          ptr_we_i,
  input  logic [1:0]    ptr_sel_i,
  input  logic [AW-1:0] ptr_wdata_i,
  input  logic [SW-1:0] stretch_i,
  input  logic          lsb_first_i,
  input  logic          shift_evt_i,
  output logic          ser_data_o,
  output logic          ser_clk_o,
  output logic          ser_strobe_o,
  output logic          busy_o
);
  logic [AW-1:0] cur_ptr;
  logic [7:0]    col_byte;
  logic          adv;

  col_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (cur_ptr),
    .rd_data_o (col_byte)
  );

  ptr_unit #(.AW(AW)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idle_i  (!busy_o),
    .we_i    (ptr_we_i),
    .sel_i   (ptr_sel_i),
    .wdata_i (ptr_wdata_i),
    .adv_i   (adv),
    .cur_o   (cur_ptr)
  );

  ser_engine #(.SW(SW)) u_ser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (shift_evt_i),
    .lsb_first_i  (lsb_first_i),
    .stretch_i    (stretch_i),
    .col_i        (col_byte),
    .ser_data_o   (ser_data_o),
    .ser_clk_o    (ser_clk_o),
    .ser_strobe_o (ser_strobe_o),
    .busy_o       (busy_o),
    .adv_o        (adv)
  );

  p_busy_cover_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_clk_o || ser_strobe_o) |-> busy_o);
  p_adv_at_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> !ser_strobe_o);
endmodule

// File: tb/col_streamer_tb.sv
module col_streamer_tb_top;
  localparam int DEPTH = 64;
  localparam int SW    = 4;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, ptr_we = 0, lsb = 0, evt = 0;
  logic [AW-1:0] wr_addr = '0, ptr_wdata = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] ptr_sel = '0;
  logic [SW-1:0] stretch = '0;
  logic ser_data, ser_clk, ser_strobe, busy;

  int checks = 0, errors = 0, cyc = 0;
  int exp_len = 1;
  int pulses = 0, strobes = 0, ph_err = 0, ncap = 0;
  int run_hi = 0, run_lo = 0, run_stb = 0;
  logic p_clk = 0, p_stb = 0, busy_at_fall = 0;
  logic [7:0] shb = '0;
  logic [7:0] cap [16];

  // {lsb_first[12], stretch[11:8], expected column[7:0]}
  localparam logic [12:0] VEC [8] = '{
    13'h0099, 13'h01BE, 13'h104F, 13'h0200,
    13'h1399, 13'h00BE, 13'h054F, 13'h1100
  };

  always #10 clk = ~clk;

  col_streamer #(.DEPTH(DEPTH), .SW(SW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .ptr_we_i(ptr_we), .ptr_sel_i(ptr_sel), .ptr_wdata_i(ptr_wdata),
    .stretch_i(stretch), .lsb_first_i(lsb), .shift_evt_i(evt),
    .ser_data_o(ser_data), .ser_clk_o(ser_clk), .ser_strobe_o(ser_strobe),
    .busy_o(busy)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog all-reqs act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // pin monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (ser_clk) begin
        if (!p_clk) begin
          pulses++;
          shb = lsb ? {ser_data, shb[7:1]} : {shb[6:0], ser_data};
          if (run_lo != exp_len) ph_err++;
          run_lo = 0;
        end
        run_hi++;
      end else begin
        if (p_clk) begin
          if (run_hi != exp_len) ph_err++;
          run_hi = 0;
        end
        if (busy && !ser_strobe) run_lo++;
      end
      if (ser_strobe) begin
        if (!p_stb) strobes++;
        if (ser_clk) ph_err++;
        run_lo = 0;
        run_stb++;
      end else if (p_stb) begin
        if (run_stb != exp_len) ph_err++;
        run_stb = 0;
        busy_at_fall = busy;
        if (ncap < 16) cap[ncap] = shb;
        ncap++;
      end
      p_clk = ser_clk;
      p_stb = ser_strobe;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    pulses = 0; strobes = 0; ph_err = 0; ncap = 0;
  endtask

  task automatic fire();
    @(posedge clk); #1 evt = 1'b1;
    @(posedge clk); #1 evt = 1'b0;
  endtask

  task automatic wait_idle();
    int idle_n = 0;
    while (idle_n < 3) begin
      @(negedge clk);
      if (!busy) idle_n++; else idle_n = 0;
    end
    #1;
  endtask

  task automatic wr_ptr(input logic [1:0] sel, input logic [AW-1:0] val);
    @(negedge clk); ptr_we = 1'b1; ptr_sel = sel; ptr_wdata = val;
    @(negedge clk); ptr_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!ser_clk && !ser_strobe && !ser_data && !busy, "R10 reset outputs",
        {ser_clk, ser_strobe, ser_data, busy}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(i);
      wr_data = (i == 3) ? 8'd0 : 8'((i * 37 + 5) & 255);
    end
    @(negedge clk); wr_en = 1'b0;
    #1 chk(!busy, "R10 idle after reset", busy, 0);

    // first column after reset comes from address 0
    clear_mon(); lsb = 0; stretch = '0; exp_len = 1;
    fire(); wait_idle();
    chk(ncap == 1 && cap[0] == 8'd5, "R10 first column addr 0", cap[0], 5);

    wr_ptr(2'd2, AW'(2));
    wr_ptr(2'd1, AW'(6));
    wr_ptr(2'd0, AW'(4));
    wr_ptr(2'd3, AW'(9)); // select 3: no effect

    // vector table: pointer runs 4,5,2,3,4,5,2,3
    for (int v = 0; v < 8; v++) begin
      lsb = VEC[v][12]; stretch = VEC[v][11:8]; exp_len = int'(VEC[v][11:8]) + 1;
      clear_mon();
      fire();
      @(negedge clk);
      chk(busy, "R8 busy after accept", busy, 1);
      wait_idle();
      chk(cap[0] == VEC[v][7:0], lsb ? "R11 lsb-first column R4 R5" : "R1 msb-first column R4 R5",
          cap[0], VEC[v][7:0]);
      chk(pulses == 8, "R2 eight clocks", pulses, 8);
      chk(strobes == 1, "R3 one strobe", strobes, 1);
      chk(ph_err == 0, "R6 phase lengths", ph_err, 0);
      chk(!busy_at_fall, "R8 busy falls with strobe", busy_at_fall, 0);
    end

    // R7: second event during transfer is kept
    lsb = 0; stretch = 4'd1; exp_len = 2; clear_mon();
    fire();
    repeat (4) @(negedge clk);
    fire();
    wait_idle();
    chk(ncap == 2, "R7 pending event served", ncap, 2);
    chk(cap[0] == 8'd153 && cap[1] == 8'd190, "R7 pending column order R4",
        {cap[0], cap[1]}, {8'd153, 8'd190});
    chk(ph_err == 0, "R6 phases with pending", ph_err, 0);

    // R9: pointer write while busy is ignored
    clear_mon();
    fire();
    repeat (3) @(negedge clk);
    wr_ptr(2'd0, AW'(0));
    wait_idle();
    fire(); wait_idle();
    chk(ncap == 2 && cap[0] == 8'd79, "R9 column before write", cap[0], 79);
    chk(cap[1] == 8'd0, "R9 busy write ignored R5", cap[1], 0);

    // idle pointer write takes effect, then wrap to restart
    wr_ptr(2'd0, AW'(5));
    clear_mon();
    fire(); wait_idle();
    fire(); wait_idle();
    chk(ncap == 2 && cap[0] == 8'd190, "R9 idle write applied", cap[0], 190);
    chk(cap[1] == 8'd79, "R4 wrap to restart", cap[1], 79);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule